// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host processor a narrow window into a network controller's local buffer memory. The host programs a 16-bit byte address and a 16-bit byte count, one byte at a time. It then reads or writes a single data port repeatedly. Each data-port strobe performs exactly one local memory transfer, either one byte or one little-endian 16-bit word, as chosen by a configuration bit. After each transfer the address steps forward and folds back to the ring's first page when it lands exactly on the ring's stop page. The count runs down, and a completion status bit is raised when the count runs out.

Local memory is reachable only in two windows: a small low area and the packet buffer range. A transfer that falls outside both never strobes the memory. A read outside the windows returns all ones. Issuing a remote read or remote write command while the count is already zero reports completion at once. The completion bit stays set until the host writes a one to it.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, every readable register (address halves, count halves, configuration, status, ring first page, ring stop page) reads zero.
- R2: Register offsets are: 0 address low byte, 1 address high byte, 2 count low byte, 3 count high byte, 4 configuration, 5 command, 6 status, 7 ring first page, 8 ring stop page. A write to one half of the address or count changes only that half. Every register reads back what was written, except the command register, which reads zero.
- R3: With configuration bit 0 clear (byte mode), each data-port access moves one byte on memory data bits 7:0, with `mem_wide` low. It adds 1 to the address and takes 1 from the count. Read data has its upper byte zero.
- R4: With configuration bit 0 set (word mode), each access drives `mem_wide` high on an even memory address, which is the held address with bit 0 cleared. Data bits 7:0 map to the even byte and bits 15:8 to the odd byte. The held address advances by 2 and the count drops by 2.
- R5: After each step, if the new address equals the ring stop page times 256, the address is reloaded with the ring first page times 256. An address that steps past the stop address without equalling it is kept.
- R6: When the count before an access is less than or equal to the transfer size, the count becomes 0 and status bit 6 (0x40) is set. Otherwise the count drops by the transfer size and status is unchanged.
- R7: A data-port write while the count is zero does nothing: no memory strobe, and address, count and status keep their values. A data-port read at count zero still transfers, advances the address and sets status bit 6.
- R8: A write to the command register with bit 0 (remote read) or bit 1 (remote write) set, while the count is zero, sets status bit 6 on the next cycle. With a nonzero count, or with neither bit set, the write leaves status unchanged.
- R9: Memory is strobed only when the access address is below `LOW_WIN`, or is at least `PKT_LO` and below `PKT_HI`. Outside these windows a read returns 0x00FF in byte mode or 0xFFFF in word mode, a write is dropped, and address and count still step.
- R10: Status bit 6 stays set until the host writes status with bit 6 set. Writing status with bit 6 clear leaves it set. If a completion and a clear fall in the same cycle, the completion wins.
- R11: When a host register write to one half of the address or count falls in the same cycle as a data-port access, that register takes the written byte in place of the step. Its other half keeps its value from before the access. The register not written still steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Register offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| dp_wr | input | 1 | Data-port write strobe (one transfer per cycle high) |
| dp_rd | input | 1 | Data-port read strobe; a simultaneous `dp_wr` takes precedence |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data, valid while `dp_rd` is high |
| mem_addr | output | AW | Local memory byte address |
| mem_rd | output | 1 | Local memory read strobe |
| mem_wr | output | 1 | Local memory write strobe |
| mem_wide | output | 1 | High for a two-byte transfer |
| mem_wdata | output | 16 | Local memory write data |
| mem_rdata | input | 16 | Local memory read data, combinational from `mem_addr` |

## Verification
Two functions can fall in one clock: the count running out on a data-port access, and a host register write that targets the same state. The bench provokes this by raising a data-port strobe and a register write in the same cycle. It pairs the last-count read with a status clear, a non-final read with a status clear, and accesses with count or address byte loads. It judges each case by reading the registers back afterwards. Completion must survive a clear issued with it, a clear with no completion must take effect, and a loaded byte must replace the step only in the register it targets.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  localparam int BYTE_W = 8;
  localparam int PORT_W = 16;

  typedef enum logic [3:0] {
    RG_ADDR_LO = 4'd0,
    RG_ADDR_HI = 4'd1,
    RG_CNT_LO  = 4'd2,
    RG_CNT_HI  = 4'd3,
    RG_CFG     = 4'd4,
    RG_CMD     = 4'd5,
    RG_STAT    = 4'd6,
    RG_RING_LO = 4'd7,
    RG_RING_HI = 4'd8
  } rdma_reg_e;

  localparam int CFG_WORD_BIT  = 0;
  localparam int CMD_RD_BIT    = 0;
  localparam int CMD_WR_BIT    = 1;
  localparam int STAT_DONE_BIT = 6;

endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [3:0]           reg_addr,
  input  logic [BYTE_W-1:0]    reg_wdata,
  output logic [BYTE_W-1:0]    reg_rdata,
  input  logic                 step_en,
  input  logic [AW-1:0]        addr_nxt,
  input  logic [CW-1:0]        cnt_nxt,
  input  logic                 xfer_done,
  output logic [AW-1:0]        addr_q,
  output logic [CW-1:0]        cnt_q,
  output logic                 word_mode,
  output logic [AW-BYTE_W-1:0] ring_lo,
  output logic [AW-BYTE_W-1:0] ring_hi,
  output logic                 done_q,
  output logic                 addr_load,
  output logic                 cnt_load,
  output logic                 done_clr,
  output logic                 kick_empty
);

  localparam int PW  = AW - BYTE_W;
  localparam int CHW = CW - BYTE_W;

  logic wr_alo, wr_ahi, wr_clo, wr_chi, wr_cfg, wr_cmd, wr_stat, wr_rlo, wr_rhi;
  logic done_set;

  assign wr_alo  = reg_wr && (reg_addr == RG_ADDR_LO);
  assign wr_ahi  = reg_wr && (reg_addr == RG_ADDR_HI);
  assign wr_clo  = reg_wr && (reg_addr == RG_CNT_LO);
  assign wr_chi  = reg_wr && (reg_addr == RG_CNT_HI);
  assign wr_cfg  = reg_wr && (reg_addr == RG_CFG);
  assign wr_cmd  = reg_wr && (reg_addr == RG_CMD);
  assign wr_stat = reg_wr && (reg_addr == RG_STAT);
  assign wr_rlo  = reg_wr && (reg_addr == RG_RING_LO);
  assign wr_rhi  = reg_wr && (reg_addr == RG_RING_HI);

  assign addr_load  = wr_alo || wr_ahi;
  assign cnt_load   = wr_clo || wr_chi;
  assign done_clr   = wr_stat && reg_wdata[STAT_DONE_BIT];
  assign kick_empty = wr_cmd && (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT])
                      && (cnt_q == '0);
  assign done_set   = xfer_done || kick_empty;

  // Address: a byte load replaces the step for this register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (wr_alo) begin
      addr_q[BYTE_W-1:0] <= reg_wdata;
    end else if (wr_ahi) begin
      addr_q[AW-1:BYTE_W] <= PW'(reg_wdata);
    end else if (step_en) begin
      addr_q <= addr_nxt;
    end
  end

  // Count: same precedence as the address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_clo) begin
      cnt_q[BYTE_W-1:0] <= reg_wdata;
    end else if (wr_chi) begin
      cnt_q[CW-1:BYTE_W] <= CHW'(reg_wdata);
    end else if (step_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_mode <= 1'b0;
      ring_lo   <= '0;
      ring_hi   <= '0;
    end else begin
      if (wr_cfg) word_mode <= reg_wdata[CFG_WORD_BIT];
      if (wr_rlo) ring_lo   <= PW'(reg_wdata);
      if (wr_rhi) ring_hi   <= PW'(reg_wdata);
    end
  end

  // Completion flag: a new completion outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_set || (done_q && !done_clr);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RG_ADDR_LO: reg_rdata = addr_q[BYTE_W-1:0];
      RG_ADDR_HI: reg_rdata = BYTE_W'(addr_q >> BYTE_W);
      RG_CNT_LO:  reg_rdata = cnt_q[BYTE_W-1:0];
      RG_CNT_HI:  reg_rdata = BYTE_W'(cnt_q >> BYTE_W);
      RG_CFG:     reg_rdata[CFG_WORD_BIT] = word_mode;
      RG_STAT:    reg_rdata[STAT_DONE_BIT] = done_q;
      RG_RING_LO: reg_rdata = BYTE_W'(ring_lo);
      RG_RING_HI: reg_rdata = BYTE_W'(ring_hi);
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rdma_step.sv
module rdma_step
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic [AW-1:0]        addr_q,
  input  logic [CW-1:0]        cnt_q,
  input  logic                 word_mode,
  input  logic [AW-BYTE_W-1:0] ring_lo,
  input  logic [AW-BYTE_W-1:0] ring_hi,
  output logic [AW-1:0]        addr_nxt,
  output logic [CW-1:0]        cnt_nxt,
  output logic                 last_xfer,
  output logic                 wrap_hit
);

  function automatic logic [AW-1:0] f_page_base(input logic [AW-BYTE_W-1:0] pg);
    return {pg, {BYTE_W{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] f_sum(input logic [AW-1:0] a, input logic wide);
    return a + (wide ? AW'(2) : AW'(1));
  endfunction

  function automatic logic [CW-1:0] f_countdown(input logic [CW-1:0] c, input logic wide);
    logic [CW-1:0] sz;
    sz = wide ? CW'(2) : CW'(1);
    return (c <= sz) ? '0 : (c - sz);
  endfunction

  logic [AW-1:0] sum;

  assign sum       = f_sum(addr_q, word_mode);
  assign wrap_hit  = (sum == f_page_base(ring_hi));
  assign addr_nxt  = wrap_hit ? f_page_base(ring_lo) : sum;
  assign cnt_nxt   = f_countdown(cnt_q, word_mode);
  assign last_xfer = word_mode ? (cnt_q <= CW'(2)) : (cnt_q <= CW'(1));

endmodule

// File: rtl/rdma_memif.sv
module rdma_memif
  import rdma_pkg::*;
#(
  parameter int          AW      = 16,
  parameter logic [AW-1:0] LOW_WIN = 16'h0020,
  parameter logic [AW-1:0] PKT_LO  = 16'h4000,
  parameter logic [AW-1:0] PKT_HI  = 16'h8000
) (
  input  logic [AW-1:0]     addr_q,
  input  logic              word_mode,
  input  logic              do_rd,
  input  logic              do_wr,
  input  logic [PORT_W-1:0] dp_wdata,
  input  logic [PORT_W-1:0] mem_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_wide,
  output logic [PORT_W-1:0] mem_wdata,
  output logic [PORT_W-1:0] dp_rdata,
  output logic              in_window
);

  function automatic logic f_in_window(input logic [AW-1:0] a);
    return (a < LOW_WIN) || ((a >= PKT_LO) && (a < PKT_HI));
  endfunction

  assign mem_addr  = word_mode ? {addr_q[AW-1:1], 1'b0} : addr_q;
  assign in_window = f_in_window(mem_addr);
  assign mem_wide  = word_mode;
  assign mem_rd    = do_rd && in_window;
  assign mem_wr    = do_wr && in_window;
  assign mem_wdata = word_mode ? dp_wdata : {{BYTE_W{1'b0}}, dp_wdata[BYTE_W-1:0]};

  always_comb begin
    if (!in_window) begin
      dp_rdata = word_mode ? '1 : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    end else if (word_mode) begin
      dp_rdata = mem_rdata;
    end else begin
      dp_rdata = {{BYTE_W{1'b0}}, mem_rdata[BYTE_W-1:0]};
    end
  end

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int            AW      = 16,
  parameter int            CW      = 16,
  parameter logic [AW-1:0] LOW_WIN = 16'h0020,
  parameter logic [AW-1:0] PKT_LO  = 16'h4000,
  parameter logic [AW-1:0] PKT_HI  = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              dp_wr,
  input  logic              dp_rd,
  input  logic [15:0]       dp_wdata,
  output logic [15:0]       dp_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_wide,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);

  localparam int PW = AW - BYTE_W;

  logic [AW-1:0] addr_q, addr_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [PW-1:0] ring_lo, ring_hi;
  logic          word_mode, done_q;
  logic          addr_load, cnt_load, done_clr, kick_empty;
  logic          last_xfer, wrap_hit, in_window;

  // Named access events
  logic wr_accept, rd_accept, acc_fire, xfer_done;

  assign wr_accept = dp_wr && (cnt_q != '0);
  assign rd_accept = dp_rd && !dp_wr;
  assign acc_fire  = wr_accept || rd_accept;
  assign xfer_done = acc_fire && last_xfer;

  rdma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .step_en    (acc_fire),
    .addr_nxt   (addr_nxt),
    .cnt_nxt    (cnt_nxt),
    .xfer_done  (xfer_done),
    .addr_q     (addr_q),
    .cnt_q      (cnt_q),
    .word_mode  (word_mode),
    .ring_lo    (ring_lo),
    .ring_hi    (ring_hi),
    .done_q     (done_q),
    .addr_load  (addr_load),
    .cnt_load   (cnt_load),
    .done_clr   (done_clr),
    .kick_empty (kick_empty)
  );

  rdma_step #(.AW(AW), .CW(CW)) u_step (
    .addr_q    (addr_q),
    .cnt_q     (cnt_q),
    .word_mode (word_mode),
    .ring_lo   (ring_lo),
    .ring_hi   (ring_hi),
    .addr_nxt  (addr_nxt),
    .cnt_nxt   (cnt_nxt),
    .last_xfer (last_xfer),
    .wrap_hit  (wrap_hit)
  );

  rdma_memif #(.AW(AW), .LOW_WIN(LOW_WIN), .PKT_LO(PKT_LO), .PKT_HI(PKT_HI)) u_memif (
    .addr_q    (addr_q),
    .word_mode (word_mode),
    .do_rd     (rd_accept),
    .do_wr     (wr_accept),
    .dp_wdata  (dp_wdata),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wide  (mem_wide),
    .mem_wdata (mem_wdata),
    .dp_rdata  (dp_rdata),
    .in_window (in_window)
  );

endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk #(
  parameter int            AW      = 16,
  parameter int            CW      = 16,
  parameter logic [AW-1:0] LOW_WIN = 16'h0020,
  parameter logic [AW-1:0] PKT_LO  = 16'h4000,
  parameter logic [AW-1:0] PKT_HI  = 16'h8000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          dp_wr,
  input logic          dp_rd,
  input logic [15:0]   dp_rdata,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_wide,
  input logic [AW-1:0] addr_q,
  input logic [CW-1:0] cnt_q,
  input logic [AW-9:0] ring_lo,
  input logic          acc_fire,
  input logic          last_xfer,
  input logic          wrap_hit,
  input logic          addr_load,
  input logic          cnt_load,
  input logic          done_q,
  input logic          done_clr
);

  AST_WR_EMPTY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && cnt_q == '0) |-> !mem_wr); // R7

  AST_WR_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && cnt_q == '0 && !addr_load && !cnt_load) |=> (addr_q == $past(addr_q) && cnt_q == '0)); // R7

  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wide && (mem_rd || mem_wr)) |-> !mem_addr[0]); // R4

  AST_MEM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> ((mem_addr < LOW_WIN) || (mem_addr >= PKT_LO && mem_addr < PKT_HI))); // R9

  AST_OOW_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd && !dp_wr && !mem_rd) |-> (dp_rdata[7:0] == 8'hFF)); // R9

  AST_LAST_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && last_xfer) |=> done_q); // R6

  AST_CNT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !cnt_load) |=> (cnt_q == '0 || cnt_q < $past(cnt_q))); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !done_clr) |=> done_q); // R10

  AST_EMPTY_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd5 && reg_wdata[1:0] != 2'b00 && cnt_q == '0) |=> done_q); // R8

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && wrap_hit && !addr_load) |=> (addr_q == {$past(ring_lo), 8'h00})); // R5

endmodule

bind rdma_port_engine rdma_port_engine_chk #(
  .AW(AW), .CW(CW), .LOW_WIN(LOW_WIN), .PKT_LO(PKT_LO), .PKT_HI(PKT_HI)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .dp_wr     (dp_wr),
  .dp_rd     (dp_rd),
  .dp_rdata  (dp_rdata),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_wide  (mem_wide),
  .addr_q    (addr_q),
  .cnt_q     (cnt_q),
  .ring_lo   (ring_lo),
  .acc_fire  (acc_fire),
  .last_xfer (last_xfer),
  .wrap_hit  (wrap_hit),
  .addr_load (addr_load),
  .cnt_load  (cnt_load),
  .done_q    (done_q),
  .done_clr  (done_clr)
);

// File: tb/sim_rdma_port_engine.sv
module sim_rdma_port_engine;

  localparam int CLK_P = 10;
  localparam logic [3:0] IX_ALO = 4'd0, IX_AHI = 4'd1, IX_CLO = 4'd2, IX_CHI = 4'd3,
                         IX_CFG = 4'd4, IX_CMD = 4'd5, IX_STAT = 4'd6,
                         IX_RLO = 4'd7, IX_RHI = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        dp_wr = 1'b0, dp_rd = 1'b0;
  logic [15:0] dp_wdata = '0;
  logic [15:0] dp_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, mem_wide;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  logic [7:0] bmem [int];

  always #(CLK_P/2) clk = ~clk;

  rdma_port_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_wr(dp_wr), .dp_rd(dp_rd),
    .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wide(mem_wide), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Byte-addressed memory model, little-endian pairs
  always @(posedge clk) begin
    if (mem_wr) begin
      bmem[int'(mem_addr)] = mem_wdata[7:0];
      if (mem_wide) bmem[int'(mem_addr) + 1] = mem_wdata[15:8];
    end
  end

  function automatic logic [7:0] peek(input int a);
    return bmem.exists(a) ? bmem[a] : 8'h00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] ix, input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ix; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] ix, output logic [7:0] v);
    @(negedge clk);
    reg_addr = ix;
    #1 v = reg_rdata;
  endtask

  task automatic set_addr(input logic [15:0] a);
    wr_reg(IX_ALO, a[7:0]); wr_reg(IX_AHI, a[15:8]);
  endtask

  task automatic set_cnt(input logic [15:0] c);
    wr_reg(IX_CLO, c[7:0]); wr_reg(IX_CHI, c[15:8]);
  endtask

  task automatic get_addr(output logic [15:0] a);
    logic [7:0] lo, hi;
    rd_reg(IX_ALO, lo); rd_reg(IX_AHI, hi); a = {hi, lo};
  endtask

  task automatic get_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd_reg(IX_CLO, lo); rd_reg(IX_CHI, hi); c = {hi, lo};
  endtask

  task automatic get_done(output logic d);
    logic [7:0] s;
    rd_reg(IX_STAT, s); d = s[6];
  endtask

  task automatic dp_write(input logic [15:0] d, output logic saw_wr, output logic [15:0] saw_a);
    @(negedge clk);
    dp_wr = 1'b1; dp_wdata = d;
    #1 saw_wr = mem_wr; saw_a = mem_addr;
    @(negedge clk);
    dp_wr = 1'b0;
  endtask

  task automatic dp_read(output logic [15:0] d, output logic saw_rd, output logic [15:0] saw_a);
    @(negedge clk);
    dp_rd = 1'b1;
    #1 mem_rdata = {peek(int'(mem_addr) + 1), peek(int'(mem_addr))};
    #1 d = dp_rdata; saw_rd = mem_rd; saw_a = mem_addr;
    @(negedge clk);
    dp_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int i = 0; i <= 8; i++) begin
      rd_reg(4'(i), v);
      check($sformatf("R1 reset reg %0d", i), v, 8'h00);
    end
  endtask

  task automatic t_halves;
    logic [15:0] a;
    logic [7:0] v;
    set_addr(16'h1234);
    wr_reg(IX_ALO, 8'h56);
    get_addr(a); check("R2 addr low half only", a, 16'h1256);
    wr_reg(IX_AHI, 8'h9A);
    get_addr(a); check("R2 addr high half only", a, 16'h9A56);
    set_cnt(16'h0A0B);
    wr_reg(IX_CHI, 8'h03);
    get_cnt(a); check("R2 count high half only", a, 16'h030B);
    wr_reg(IX_RLO, 8'h40); rd_reg(IX_RLO, v); check("R2 ring first readback", v, 8'h40);
    wr_reg(IX_RHI, 8'h60); rd_reg(IX_RHI, v); check("R2 ring stop readback", v, 8'h60);
    wr_reg(IX_CFG, 8'h01); rd_reg(IX_CFG, v); check("R2 cfg readback", v, 8'h01);
    wr_reg(IX_CFG, 8'h00);
    set_cnt(16'h0005);
    wr_reg(IX_CMD, 8'h00); rd_reg(IX_CMD, v); check("R2 cmd reads zero", v, 8'h00);
  endtask

  task automatic t_byte_mode;
    logic [15:0] a, c, sa, d;
    logic sw, dn;
    wr_reg(IX_CFG, 8'h00);
    set_addr(16'h4000); set_cnt(16'h0003);
    dp_write(16'h77A1, sw, sa);
    check("R3 byte write strobe", sw, 1'b1);
    check("R3 byte write addr", sa, 16'h4000);
    dp_write(16'h00B2, sw, sa);
    get_cnt(c); check("R6 count after two bytes", c, 16'h0001);
    get_done(dn); check("R6 not done with count left", dn, 1'b0);
    dp_write(16'h00C3, sw, sa);
    get_addr(a); check("R3 addr after three bytes", a, 16'h4003);
    get_cnt(c); check("R6 count exhausted", c, 16'h0000);
    get_done(dn); check("R6 done on last byte", dn, 1'b1);
    check("R3 byte lane memory", {peek(32'h4000), peek(32'h4001), peek(32'h4002)}, 24'hA1B2C3);
    dp_write(16'h00EE, sw, sa);
    check("R7 write at zero count no strobe", sw, 1'b0);
    get_addr(a); check("R7 write at zero count addr kept", a, 16'h4003);
    check("R7 write at zero count memory untouched", peek(32'h4003), 8'h00);
    wr_reg(IX_STAT, 8'h00);
    get_done(dn); check("R10 writing zero keeps done", dn, 1'b1);
    wr_reg(IX_STAT, 8'h40);
    get_done(dn); check("R10 write one clears done", dn, 1'b0);
    set_addr(16'h4001); set_cnt(16'h0004);
    dp_read(d, sw, sa);
    check("R3 byte read upper zero", d, 16'h00B2);
  endtask

  task automatic t_word_mode;
    logic [15:0] a, c, sa, d;
    logic sw, dn;
    wr_reg(IX_CFG, 8'h01);
    set_addr(16'h4011); set_cnt(16'h0005);
    dp_write(16'hBEEF, sw, sa);
    check("R4 word addr forced even", sa, 16'h4010);
    check("R4 little-endian pair", {peek(32'h4011), peek(32'h4010)}, 16'hBEEF);
    get_addr(a); check("R4 held addr +2", a, 16'h4013);
    get_cnt(c); check("R4 count -2", c, 16'h0003);
    dp_write(16'h1122, sw, sa);
    dp_write(16'h3344, sw, sa);
    get_cnt(c); check("R6 word count 1 exhausts", c, 16'h0000);
    get_done(dn); check("R6 word done", dn, 1'b1);
    wr_reg(IX_STAT, 8'h40);
    set_addr(16'h4010); set_cnt(16'h0002);
    dp_read(d, sw, sa);
    check("R4 word read data", d, 16'hBEEF);
    get_done(dn); check("R6 count equal to size completes", dn, 1'b1);
    wr_reg(IX_STAT, 8'h40);
  endtask

  task automatic t_wrap;
    logic [15:0] a, sa, d;
    logic sw;
    wr_reg(IX_RLO, 8'h40); wr_reg(IX_RHI, 8'h42);
    wr_reg(IX_CFG, 8'h00);
    set_addr(16'h41FE); set_cnt(16'h0010);
    dp_read(d, sw, sa); dp_read(d, sw, sa);
    get_addr(a); check("R5 byte wrap to first page", a, 16'h4000);
    wr_reg(IX_CFG, 8'h01);
    set_addr(16'h41FE);
    dp_read(d, sw, sa);
    get_addr(a); check("R5 word wrap to first page", a, 16'h4000);
    set_addr(16'h41FD);
    dp_read(d, sw, sa); dp_read(d, sw, sa);
    get_addr(a); check("R5 step past stop kept", a, 16'h4201);
    wr_reg(IX_RHI, 8'h60);
    wr_reg(IX_STAT, 8'h40);
  endtask

  task automatic t_window;
    logic [15:0] a, c, sa, d;
    logic sw;
    wr_reg(IX_CFG, 8'h00);
    set_addr(16'h0100); set_cnt(16'h0004);
    dp_read(d, sw, sa);
    check("R9 byte read outside ones", d, 16'h00FF);
    check("R9 no read strobe outside", sw, 1'b0);
    get_addr(a); check("R9 addr steps outside", a, 16'h0101);
    set_addr(16'h001F);
    dp_read(d, sw, sa);
    check("R9 low window read strobe", sw, 1'b1);
    wr_reg(IX_CFG, 8'h01);
    set_addr(16'h8000);
    dp_read(d, sw, sa);
    check("R9 word read outside ones", d, 16'hFFFF);
    wr_reg(IX_CFG, 8'h00);
    set_addr(16'h0020); set_cnt(16'h0002);
    dp_write(16'h0055, sw, sa);
    check("R9 write outside dropped", sw, 1'b0);
    get_cnt(c); check("R9 count steps outside", c, 16'h0001);
    wr_reg(IX_STAT, 8'h40);
  endtask

  task automatic t_zero_kick;
    logic [15:0] a, sa, d;
    logic dn, sw;
    set_cnt(16'h0000); wr_reg(IX_STAT, 8'h40);
    wr_reg(IX_CMD, 8'h01); get_done(dn); check("R8 read kick at zero", dn, 1'b1);
    wr_reg(IX_STAT, 8'h40);
    wr_reg(IX_CMD, 8'h02); get_done(dn); check("R8 write kick at zero", dn, 1'b1);
    wr_reg(IX_STAT, 8'h40);
    wr_reg(IX_CMD, 8'h04); get_done(dn); check("R8 other bits no kick", dn, 1'b0);
    set_cnt(16'h0005);
    wr_reg(IX_CMD, 8'h01); get_done(dn); check("R8 nonzero count no kick", dn, 1'b0);
    wr_reg(IX_CFG, 8'h00);
    set_cnt(16'h0000); set_addr(16'h4020);
    dp_read(d, sw, sa);
    get_addr(a); check("R7 read at zero count steps", a, 16'h4021);
    get_done(dn); check("R7 read at zero count done", dn, 1'b1);
    wr_reg(IX_STAT, 8'h40);
  endtask

  task automatic t_same_cycle;
    logic [15:0] a, c;
    logic dn;
    wr_reg(IX_CFG, 8'h00);
    set_addr(16'h4010); set_cnt(16'h0001);
    @(negedge clk);
    dp_rd = 1'b1; reg_wr = 1'b1; reg_addr = IX_STAT; reg_wdata = 8'h40;
    @(negedge clk);
    dp_rd = 1'b0; reg_wr = 1'b0;
    get_done(dn); check("R10 completion beats clear", dn, 1'b1);
    set_cnt(16'h0005);
    @(negedge clk);
    dp_rd = 1'b1; reg_wr = 1'b1; reg_addr = IX_STAT; reg_wdata = 8'h40;
    @(negedge clk);
    dp_rd = 1'b0; reg_wr = 1'b0;
    get_done(dn); check("R10 clear with non-final access", dn, 1'b0);
    set_addr(16'h4010); set_cnt(16'h0105);
    @(negedge clk);
    dp_wr = 1'b1; dp_wdata = 16'h0099; reg_wr = 1'b1; reg_addr = IX_CLO; reg_wdata = 8'h07;
    @(negedge clk);
    dp_wr = 1'b0; reg_wr = 1'b0;
    get_cnt(c); check("R11 count load beats step", c, 16'h0107);
    get_addr(a); check("R11 addr still steps", a, 16'h4011);
    @(negedge clk);
    dp_rd = 1'b1; reg_wr = 1'b1; reg_addr = IX_AHI; reg_wdata = 8'h45;
    @(negedge clk);
    dp_rd = 1'b0; reg_wr = 1'b0;
    get_addr(a); check("R11 addr load keeps other half", a, 16'h4511);
    get_cnt(c); check("R11 count still steps", c, 16'h0106);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_halves();
    t_byte_mode();
    t_word_mode();
    t_wrap();
    t_window();
    t_zero_kick();
    t_same_cycle();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule